// File: doc/BRIEF.md
# NAND Page Command Address Sequencer

This block produces the opening phase of a page access on a raw NAND device. Each request carries an opcode, a page (row) number, a spare-only flag, a page-class selector and an address-cycle count. From these the block emits a command byte, the column bytes, the row bytes and, for a large-page read, a trailing read-start command. Each byte goes out on a byte-wide strobe interface, and a flag marks whether the byte is a command or an address.

Every byte is announced by a strobe that lasts one cycle. The byte stays on the bus until the downstream pin driver accepts it. The driver may accept in the strobe cycle itself or in any later cycle. After the last byte is accepted, the block watches the device ready line for a bounded number of cycles. It then reports completion with a done pulse, and raises a timeout flag alongside the pulse if ready never came. Data transfer, ECC and the program-confirm phase are handled by other logic.

Top module: `nand_page_cmd_seq`

## Requirements
- R1: After reset, strobe_o, busy_o, done_o and timeout_o are all 0.
- R2: With large_page_i=0, spare_only_i=1 and opcode_i=0x00, the command byte sent is 0x50. Any other opcode, and any request with spare_only_i=0, sends opcode_i unchanged.
- R3: With large_page_i=0, the bytes sent are, in order: command (is_cmd_o=1), then column 0x00, page[7:0] and page[15:8] (is_cmd_o=0). page[23:16] follows when addr_cycles_i >= 4, and page[31:24] follows that when addr_cycles_i >= 5.
- R4: With large_page_i=1, the command byte is opcode_i unchanged. It is followed by two column bytes: 0x00 then 0x00, or 0x00 then 0x08 when spare_only_i=1.
- R5: With large_page_i=1, the column bytes are followed by page[7:0] and page[15:8]. page[23:16] is added only when addr_cycles_i >= 5.
- R6: With large_page_i=1 and opcode_i=0x00, one more command byte 0x30 is sent after the row bytes. No other opcode gets this byte.
- R7: strobe_o is high for exactly one cycle per byte. bus_byte_o and is_cmd_o hold until accept_i is high. The next byte's strobe comes in the cycle right after the accepting cycle.
- R8: After the final accept, if ready_i is seen high in one of the first TIMEOUT_TICKS cycles, then done_o pulses in the next cycle with timeout_o=0.
- R9: If ready_i stays low for TIMEOUT_TICKS cycles after the final accept, then done_o and timeout_o pulse together TIMEOUT_TICKS cycles after that accept.
- R10: start_i is ignored while busy_o is 1. The request fields are captured only when the block accepts a start, so later changes to them have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken when not busy |
| page_i | input | PAGE_W | Page (row) number |
| opcode_i | input | 8 | Access opcode (0x00 read, 0x80 program setup) |
| spare_only_i | input | 1 | Target the spare area only |
| large_page_i | input | 1 | 1 = large-page device, 0 = small-page device |
| addr_cycles_i | input | 3 | Device address-cycle count |
| strobe_o | output | 1 | One-cycle pulse announcing a new bus byte |
| is_cmd_o | output | 1 | 1 = command byte, 0 = address byte |
| bus_byte_o | output | 8 | Command or address byte |
| accept_i | input | 1 | Pin driver took the current byte |
| ready_i | input | 1 | Device ready line |
| busy_o | output | 1 | Sequence or ready wait in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | With done_o: ready never came |

## Verification
The bench builds the block with PAGE_W=32 and TIMEOUT_TICKS=6. A 32-bit page reaches every row byte, including the fourth small-page row byte. The short timeout keeps the expiry and the last-cycle ready boundary to a few cycles each. The sweep covers both page classes, cycle counts 3 to 5, the read, program and direct spare opcodes, both spare settings and two page patterns. It rotates accept delays of 0 to 2 cycles and ready delays of 0 to 5 cycles. Separate runs check the exact expiry cycle and starts that arrive mid-sequence with changed request fields.

// File: rtl/nand_pcmd_pkg.sv
package nand_pcmd_pkg;
  localparam logic [7:0] OP_READ       = 8'h00;
  localparam logic [7:0] OP_READ_START = 8'h30;
  localparam logic [7:0] OP_SPARE_READ = 8'h50;
  localparam logic [7:0] OP_PROG_SETUP = 8'h80;
  localparam logic [7:0] COL_SPARE_HI  = 8'h08;

  localparam int BEATS_MAX = 8;
  localparam int BEAT_IDX_W = $clog2(BEATS_MAX);
  localparam int BEAT_CNT_W = $clog2(BEATS_MAX + 1);

  typedef struct packed {
    logic       is_cmd;
    logic [7:0] data;
  } bus_beat_t;
endpackage

// File: rtl/nand_pcmd_builder.sv
module nand_pcmd_builder
  import nand_pcmd_pkg::*;
#(
  parameter int PAGE_W = 32
) (
  input  logic [7:0]                     opcode_i,
  input  logic                           spare_i,
  input  logic                           large_i,
  input  logic [2:0]                     cycles_i,
  input  logic [PAGE_W-1:0]              page_i,
  output bus_beat_t [BEATS_MAX-1:0]      beats_o,
  output logic [BEAT_CNT_W-1:0]          count_o
);
  localparam int PAD_W = (PAGE_W > 32) ? PAGE_W : 32;

  logic [PAD_W-1:0]      pg;
  logic                  cyc_ge4, cyc_ge5, is_read;
  logic [BEAT_IDX_W-1:0] rs_idx;

  assign pg      = PAD_W'(page_i);
  assign cyc_ge4 = cycles_i >= 3'd4;
  assign cyc_ge5 = cycles_i >= 3'd5;
  assign is_read = opcode_i == OP_READ;
  assign rs_idx  = cyc_ge5 ? BEAT_IDX_W'(6) : BEAT_IDX_W'(5);

  always_comb begin
    beats_o = '0;
    count_o = '0;
    if (!large_i) begin
      beats_o[0] = '{1'b1, (spare_i && is_read) ? OP_SPARE_READ : opcode_i};
      beats_o[1] = '{1'b0, 8'h00};
      beats_o[2] = '{1'b0, pg[7:0]};
      beats_o[3] = '{1'b0, pg[15:8]};
      beats_o[4] = '{1'b0, pg[23:16]};
      beats_o[5] = '{1'b0, pg[31:24]};
      count_o    = BEAT_CNT_W'(4) + BEAT_CNT_W'(cyc_ge4) + BEAT_CNT_W'(cyc_ge5);
    end else begin
      beats_o[0] = '{1'b1, opcode_i};
      beats_o[1] = '{1'b0, 8'h00};
      beats_o[2] = '{1'b0, spare_i ? COL_SPARE_HI : 8'h00};
      beats_o[3] = '{1'b0, pg[7:0]};
      beats_o[4] = '{1'b0, pg[15:8]};
      if (cyc_ge5) beats_o[5] = '{1'b0, pg[23:16]};
      if (is_read) beats_o[rs_idx] = '{1'b1, OP_READ_START};
      count_o = BEAT_CNT_W'(rs_idx) + BEAT_CNT_W'(is_read);
    end
  end
endmodule

// File: rtl/nand_pcmd_emitter.sv
module nand_pcmd_emitter
  import nand_pcmd_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      go_i,
  input  bus_beat_t [BEATS_MAX-1:0] beats_i,
  input  logic [BEAT_CNT_W-1:0]     count_i,
  input  logic                      accept_i,
  output logic                      strobe_o,
  output bus_beat_t                 beat_o,
  output logic                      busy_o,
  output logic                      fin_o
);
  typedef enum logic [1:0] {EM_IDLE, EM_SEND, EM_HOLD} em_state_e;

  em_state_e             state_q;
  logic [BEAT_IDX_W-1:0] idx_q;
  logic                  last;

  assign last     = {1'b0, idx_q} == (count_i - BEAT_CNT_W'(1));
  assign strobe_o = state_q == EM_SEND;
  assign busy_o   = state_q != EM_IDLE;
  assign beat_o   = beats_i[idx_q];
  assign fin_o    = busy_o && accept_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EM_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        EM_IDLE: if (go_i) begin
          state_q <= EM_SEND;
          idx_q   <= '0;
        end
        default: begin
          if (accept_i) begin
            if (last) state_q <= EM_IDLE;
            else begin
              state_q <= EM_SEND;
              idx_q   <= idx_q + 1'b1;
            end
          end else begin
            state_q <= EM_HOLD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_pcmd_ready_timer.sv
module nand_pcmd_ready_timer #(
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ready_i,
  output logic wait_o,
  output logic done_o,
  output logic timeout_o
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_o    <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      cnt_q     <= '0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (arm_i) begin
        wait_o <= 1'b1;
        cnt_q  <= '0;
      end else if (wait_o) begin
        if (ready_i) begin
          wait_o <= 1'b0;
          done_o <= 1'b1;
        end else if (cnt_q == CNT_LAST) begin
          wait_o    <= 1'b0;
          done_o    <= 1'b1;
          timeout_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nand_page_cmd_seq.sv
module nand_page_cmd_seq
  import nand_pcmd_pkg::*;
#(
  parameter int PAGE_W        = 32,
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [7:0]        opcode_i,
  input  logic              spare_only_i,
  input  logic              large_page_i,
  input  logic [2:0]        addr_cycles_i,
  output logic              strobe_o,
  output logic              is_cmd_o,
  output logic [7:0]        bus_byte_o,
  input  logic              accept_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        opcode_q;
  logic              spare_q, large_q;
  logic [2:0]        cycles_q;
  logic              take;
  logic              emit_busy, emit_fin, timer_wait;

  bus_beat_t [BEATS_MAX-1:0] beats;
  logic [BEAT_CNT_W-1:0]     beat_cnt;
  bus_beat_t                 cur_beat;

  assign busy_o = emit_busy | timer_wait;
  assign take   = start_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q   <= '0;
      opcode_q <= '0;
      spare_q  <= 1'b0;
      large_q  <= 1'b0;
      cycles_q <= '0;
    end else if (take) begin
      page_q   <= page_i;
      opcode_q <= opcode_i;
      spare_q  <= spare_only_i;
      large_q  <= large_page_i;
      cycles_q <= addr_cycles_i;
    end
  end

  nand_pcmd_builder #(.PAGE_W(PAGE_W)) u_builder (
    .opcode_i (opcode_q),
    .spare_i  (spare_q),
    .large_i  (large_q),
    .cycles_i (cycles_q),
    .page_i   (page_q),
    .beats_o  (beats),
    .count_o  (beat_cnt)
  );

  nand_pcmd_emitter u_emitter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (take),
    .beats_i  (beats),
    .count_i  (beat_cnt),
    .accept_i (accept_i),
    .strobe_o (strobe_o),
    .beat_o   (cur_beat),
    .busy_o   (emit_busy),
    .fin_o    (emit_fin)
  );

  assign is_cmd_o   = cur_beat.is_cmd;
  assign bus_byte_o = cur_beat.data;

  nand_pcmd_ready_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (emit_fin),
    .ready_i   (ready_i),
    .wait_o    (timer_wait),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );
endmodule

// File: rtl/nand_pcmd_checker.sv
module nand_pcmd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       strobe_o,
  input logic       is_cmd_o,
  input logic [7:0] bus_byte_o,
  input logic       accept_i,
  input logic       ready_i,
  input logic       done_o,
  input logic       timeout_o,
  input logic       wait_i
);
  AST_FIRST_BEAT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> strobe_o && is_cmd_o); // R3

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o && !accept_i |=> !strobe_o); // R7

  AST_BYTE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o && !accept_i |=> $stable(bus_byte_o) && $stable(is_cmd_o)); // R7

  AST_READY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i && ready_i |=> done_o && !timeout_o); // R8

  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o); // R9

  AST_NO_STROBE_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |-> !strobe_o); // R8

  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o && !accept_i |=> !strobe_o); // R10
endmodule

bind nand_page_cmd_seq nand_pcmd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .strobe_o   (strobe_o),
  .is_cmd_o   (is_cmd_o),
  .bus_byte_o (bus_byte_o),
  .accept_i   (accept_i),
  .ready_i    (ready_i),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .wait_i     (timer_wait)
);

// File: tb/nand_page_cmd_seq_tb_top.sv
module nand_page_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 32;
  localparam int TMO = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [PW-1:0] page_i = '0;
  logic [7:0]    opcode_i = '0;
  logic          spare_only_i = 1'b0;
  logic          large_page_i = 1'b0;
  logic [2:0]    addr_cycles_i = 3'd3;
  logic          accept_i = 1'b0;
  logic          ready_i = 1'b0;
  logic          strobe_o, is_cmd_o, busy_o, done_o, timeout_o;
  logic [7:0]    bus_byte_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_page_cmd_seq #(.PAGE_W(PW), .TIMEOUT_TICKS(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .page_i(page_i),
    .opcode_i(opcode_i), .spare_only_i(spare_only_i), .large_page_i(large_page_i),
    .addr_cycles_i(addr_cycles_i), .strobe_o(strobe_o), .is_cmd_o(is_cmd_o),
    .bus_byte_o(bus_byte_o), .accept_i(accept_i), .ready_i(ready_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  logic [7:0] exp_byte [8];
  bit         exp_cmd  [8];
  string      exp_tag  [8];
  int         exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit c, input logic [7:0] b, input string t);
    exp_cmd[exp_n] = c; exp_byte[exp_n] = b; exp_tag[exp_n] = t; exp_n++;
  endtask

  task automatic build_exp(input logic [7:0] op, input bit sp, input bit lg,
                           input int cyc, input logic [31:0] pg);
    exp_n = 0;
    if (!lg) begin
      if (sp && op == 8'h00) push(1, 8'h50, "R2");
      else push(1, op, "R2");
      push(0, 8'h00, "R3");
      push(0, pg[7:0], "R3");
      push(0, pg[15:8], "R3");
      if (cyc >= 4) push(0, pg[23:16], "R3");
      if (cyc >= 5) push(0, pg[31:24], "R3");
    end else begin
      push(1, op, "R4");
      push(0, 8'h00, "R4");
      push(0, sp ? 8'h08 : 8'h00, "R4");
      push(0, pg[7:0], "R5");
      push(0, pg[15:8], "R5");
      if (cyc >= 5) push(0, pg[23:16], "R5");
      if (op == 8'h00) push(1, 8'h30, "R6");
    end
  endtask

  task automatic run_op(input logic [7:0] op, input bit sp, input bit lg,
                        input int cyc, input logic [31:0] pg,
                        input int acc_dly, input int rdy_dly, input bit poke);
    logic [7:0] held;
    bit aborted = 0;
    build_exp(op, sp, lg, cyc, pg);
    @(negedge clk);
    opcode_i = op; spare_only_i = sp; large_page_i = lg;
    addr_cycles_i = 3'(cyc); page_i = pg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < exp_n && !aborted; i++) begin
      chk(strobe_o == 1'b1, "R7", "strobe present", int'(strobe_o), 1);
      if (strobe_o !== 1'b1) aborted = 1;
      else begin
        chk(bus_byte_o == exp_byte[i] && is_cmd_o == exp_cmd[i], exp_tag[i],
            $sformatf("byte %0d", i), {is_cmd_o, bus_byte_o}, {exp_cmd[i], exp_byte[i]});
        held = bus_byte_o;
        for (int j = 0; j < acc_dly; j++) begin
          @(negedge clk);
          start_i = 1'b0;
          if (poke && i == 1 && j == 0) begin
            start_i = 1'b1; opcode_i = 8'h80; page_i = ~pg;
            large_page_i = ~lg; spare_only_i = ~sp; addr_cycles_i = 3'd5;
          end
          chk(strobe_o == 1'b0 && bus_byte_o == held, "R7", "held without strobe",
              {strobe_o, bus_byte_o}, {1'b0, held});
        end
        accept_i = 1'b1;
        @(negedge clk);
        accept_i = 1'b0; start_i = 1'b0;
      end
    end
    if (aborted) begin
      repeat (3 * TMO) @(negedge clk);
      return;
    end
    chk(strobe_o == 1'b0 && busy_o == 1'b1, "R8", "no extra byte, waiting",
        {strobe_o, busy_o}, 2'b01);
    if (rdy_dly < TMO) begin
      for (int k = 0; k < rdy_dly; k++) begin
        chk(done_o == 1'b0, "R8", "early done", int'(done_o), 0);
        @(negedge clk);
      end
      ready_i = 1'b1;
      @(negedge clk);
      ready_i = 1'b0;
      chk(done_o == 1'b1 && timeout_o == 1'b0, "R8", "done after ready",
          {done_o, timeout_o}, 2'b10);
    end else begin
      for (int k = 0; k < TMO; k++) begin
        chk(done_o == 1'b0, "R9", "done before expiry", int'(done_o), 0);
        @(negedge clk);
      end
      chk(done_o == 1'b1 && timeout_o == 1'b1, "R9", "expiry", {done_o, timeout_o}, 2'b11);
    end
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "return idle", {done_o, busy_o}, 2'b00);
  endtask

  initial begin
    logic [7:0] ops [3];
    logic [31:0] pages [2];
    int n = 0;
    ops[0] = 8'h00; ops[1] = 8'h80; ops[2] = 8'h50;
    pages[0] = 32'h1234_5678; pages[1] = 32'hFEDC_BA98;
    repeat (3) @(negedge clk);
    chk(strobe_o == 0 && busy_o == 0 && done_o == 0 && timeout_o == 0, "R1",
        "reset outputs", {strobe_o, busy_o, done_o, timeout_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe_o == 0 && busy_o == 0 && done_o == 0, "R1", "after release",
        {strobe_o, busy_o, done_o}, 0);
    for (int lg = 0; lg < 2; lg++)
      for (int cyc = 3; cyc <= 5; cyc++)
        for (int o = 0; o < 3; o++)
          for (int sp = 0; sp < 2; sp++)
            for (int p = 0; p < 2; p++) begin
              run_op(ops[o], sp[0], lg[0], cyc, pages[p], n % 3, n % TMO,
                     (n % 5 == 2) && (n % 3 != 0));
              n++;
            end
    // timeout and last-cycle boundary, both classes; R9
    run_op(8'h00, 1'b0, 1'b1, 5, 32'hA5A5_5A5A, 1, TMO, 1'b0);
    run_op(8'h80, 1'b1, 1'b0, 5, 32'h0F1E_2D3C, 0, TMO, 1'b0);
    run_op(8'h00, 1'b1, 1'b0, 4, 32'h0F1E_2D3C, 2, TMO - 1, 1'b0);
    // start pokes while busy with changed fields; R10
    run_op(8'h00, 1'b0, 1'b0, 5, 32'h89AB_CDEF, 2, 1, 1'b1);
    run_op(8'h80, 1'b0, 1'b1, 4, 32'h0000_FFFF, 1, 0, 1'b1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule